// File: doc/BRIEF.md
# Dual-Source Serial Bit-Rate Tick Generator

This block derives the oversampling ticks for two serial ports from the core clock. Port A can take its rate from either of two sources. One is a timer-overflow path: a fixed divide-by-12 feeds an 8-bit counter that restarts from a programmable high-byte value. The other is an internal 10-bit counter that restarts from a programmable reload value. A select input picks the source. A doubling input halves the divide applied to port A on either source. Port B always runs from its own 10-bit reload counter and ignores both the select and the doubling inputs.

Each output is a one-cycle pulse at 16 times the bit rate, and the serial shifter divides it by 16. The resulting rates follow these formulas. On the internal source, port A runs at clk·2^d / (64·(1024−RA)). On the timer source, port A runs at clk·2^d / (384·(256−TH)). Port B runs at clk / (32·(1024−RB)). With realistic core clocks this covers 300 to 38400 bit/s. Both sources of port A run all the time, so changing the select input takes effect without a reset. A new reload value is picked up only when the counter next overflows.

Top module: `ubg_top`

## Requirements
- R1: While rst_ni is low both ticks are 0. After release, tick_b_o first pulses in the 2nd clock cycle. With src_int_i=1 and dbl_i=0, tick_a_o first pulses in the 4th cycle.
- R2: With src_int_i=1 and dbl_i=0, tick_a_o pulses every 4·(1024−rld_a_i) cycles.
- R3: With src_int_i=1 and dbl_i=1, tick_a_o pulses every 2·(1024−rld_a_i) cycles.
- R4: With src_int_i=0 and dbl_i=0, tick_a_o pulses every 24·(256−th_i) cycles.
- R5: With src_int_i=0 and dbl_i=1, tick_a_o pulses every 12·(256−th_i) cycles.
- R6: tick_b_o pulses every 2·(1024−rld_b_i) cycles, whatever the values of dbl_i and src_int_i.
- R7: Every tick is a one-cycle pulse. Under a steady configuration no tick is high in two consecutive cycles.
- R8: A reload value changed just after a tick does not alter the interval in progress. The following interval uses the new value.
- R9: The reload extremes hold. A reload of 1023 leaves only the prescale (4 or 2 cycles for port A, 2 for port B). A reload of 0 gives the longest period, 1024 counts.
- R10: Changing src_int_i or dbl_i while running, with no reset, makes tick_a_o settle to the period of the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_int_i | input | 1 | Port A source: 1 selects the internal reload counter, 0 selects the timer path |
| dbl_i | input | 1 | Doubles the port A rate |
| rld_a_i | input | 10 | Port A internal counter reload |
| th_i | input | 8 | Timer-path 8-bit reload (high byte) |
| rld_b_i | input | 10 | Port B reload |
| tick_a_o | output | 1 | Port A 16x tick |
| tick_b_o | output | 1 | Port B 16x tick |

## Verification
Every tick leaves one output register. That register captures the combinational overflow of the last counter stage. As a result, a tick appears in the cycle after the edge at which the counter wraps. The first tick after reset is therefore due at edge 2 for port B and at edge 4 for port A. The bench samples both outputs on the falling edge and counts those edges. It measures each period as the distance between the third and the fourth rising tick after a configuration change. This lets stale counter contents and the timer-path toggle phase clear before the measurement. For the reload test, the bench changes the value in the cycle after a tick. It then expects exactly one interval at the old length, followed by intervals at the new length.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
  localparam int unsigned RLD_W     = 10;
  localparam int unsigned TMR_W     = 8;
  localparam int unsigned TMR_PRE   = 12;
  localparam int unsigned A_PRE_X1  = 4;
  localparam int unsigned A_PRE_X2  = 2;
  localparam int unsigned B_PRE     = 2;
endpackage

// File: rtl/ubg_prescaler.sv
module ubg_prescaler #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] last_i,   // divide ratio minus one, must be >= 1
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;

  assign pulse_o = (cnt_q >= last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (pulse_o) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (cnt_q == '0) && !pulse_o) else $error("prescaler wrap"); // R2
endmodule

// File: rtl/ubg_reload_ctr.sv
module ubg_reload_ctr #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] rld_i,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  // starts at all-ones so the first enabled step overflows and loads rld_i
  assign ovf_o = en_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '1;
    else if (ovf_o) cnt_q <= rld_i;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  AST_RELOAD_AT_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == $past(rld_i)) else $error("reload at overflow"); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q)) else $error("counter moved while idle"); // R9
endmodule

// File: rtl/ubg_timer_path.sv
module ubg_timer_path
  import ubg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbl_i,
  input  logic [TMR_W-1:0] th_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = $clog2(TMR_PRE);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TMR_PRE - 1);

  logic pre_en, tmr_ovf, half_q;

  ubg_prescaler #(.CNT_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .last_i(PRE_LAST), .pulse_o(pre_en)
  );

  ubg_reload_ctr #(.W(TMR_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pre_en), .rld_i(th_i), .ovf_o(tmr_ovf)
  );

  // without doubling only every second overflow is passed on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      half_q <= 1'b0;
    else if (tmr_ovf) half_q <= ~half_q;
  end

  assign tick_o = tmr_ovf && (dbl_i || !half_q);

  AST_HALF_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_ovf && !dbl_i && !half_q) |=> half_q) else $error("half stage phase"); // R4
endmodule

// File: rtl/ubg_top.sv
module ubg_top
  import ubg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_int_i,
  input  logic             dbl_i,
  input  logic [RLD_W-1:0] rld_a_i,
  input  logic [TMR_W-1:0] th_i,
  input  logic [RLD_W-1:0] rld_b_i,
  output logic             tick_a_o,
  output logic             tick_b_o
);
  localparam int unsigned AP_W = $clog2(A_PRE_X1);
  localparam int unsigned BP_W = (B_PRE > 2) ? $clog2(B_PRE) : 1;
  localparam logic [AP_W-1:0] A_LAST_X1 = AP_W'(A_PRE_X1 - 1);
  localparam logic [AP_W-1:0] A_LAST_X2 = AP_W'(A_PRE_X2 - 1);
  localparam logic [BP_W-1:0] B_LAST    = BP_W'(B_PRE - 1);

  logic a_pre, a_int_tick, a_tmr_tick, b_pre, b_tick;

  // port A, internal source
  ubg_prescaler #(.CNT_W(AP_W)) u_a_pre (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .last_i(dbl_i ? A_LAST_X2 : A_LAST_X1), .pulse_o(a_pre)
  );
  ubg_reload_ctr #(.W(RLD_W)) u_a_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(a_pre), .rld_i(rld_a_i), .ovf_o(a_int_tick)
  );

  // port A, timer source
  ubg_timer_path u_a_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .dbl_i(dbl_i), .th_i(th_i), .tick_o(a_tmr_tick)
  );

  // port B, fixed prescale, no doubling
  ubg_prescaler #(.CNT_W(BP_W)) u_b_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .last_i(B_LAST), .pulse_o(b_pre)
  );
  ubg_reload_ctr #(.W(RLD_W)) u_b_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(b_pre), .rld_i(rld_b_i), .ovf_o(b_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_a_o <= 1'b0;
      tick_b_o <= 1'b0;
    end else begin
      tick_a_o <= src_int_i ? a_int_tick : a_tmr_tick;
      tick_b_o <= b_tick;
    end
  end

  AST_B_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_b_o |=> !tick_b_o) else $error("port B tick too wide"); // R7
  AST_A_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_a_o) && ($past(src_int_i) == $past(src_int_i, 2))) |-> !tick_a_o)
    else $error("port A tick too wide"); // R7
  AST_B_FOLLOWS_CTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_tick |=> tick_b_o) else $error("port B tick lost"); // R6
endmodule

// File: tb/ubg_top_test.sv
`timescale 1ns/1ps
module ubg_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_int = 1'b1, dbl = 1'b0;
  logic [9:0] rld_a = 10'd1020, rld_b = 10'd1020;
  logic [7:0] th = 8'd250;
  logic tick_a, tick_b;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  ubg_top uut (
    .clk_i(clk), .rst_ni(rst_n), .src_int_i(src_int), .dbl_i(dbl),
    .rld_a_i(rld_a), .th_i(th), .rld_b_i(rld_b),
    .tick_a_o(tick_a), .tick_b_o(tick_b)
  );

  // sel, dbl, rld_a, th, rld_b, expected period A, expected period B
  typedef struct packed {
    logic sel; logic d; logic [9:0] ra; logic [7:0] t; logic [9:0] rb;
    logic [15:0] pa; logic [15:0] pb;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 10'd1020, 8'd250, 10'd1020, 16'd16,   16'd8},
    '{1'b1, 1'b1, 10'd1020, 8'd250, 10'd1000, 16'd8,    16'd48},
    '{1'b0, 1'b0, 10'd1000, 8'd254, 10'd1023, 16'd48,   16'd2},
    '{1'b0, 1'b1, 10'd1000, 8'd250, 10'd1010, 16'd72,   16'd28},
    '{1'b1, 1'b0, 10'd1023, 8'd0,   10'd990,  16'd4,    16'd68},
    '{1'b0, 1'b0, 10'd0,    8'd243, 10'd1023, 16'd312,  16'd2},
    '{1'b1, 1'b1, 10'd1023, 8'd0,   10'd1022, 16'd2,    16'd4},
    '{1'b0, 1'b1, 10'd1023, 8'd0,   10'd0,    16'd3072, 16'd2048},
    '{1'b1, 1'b0, 10'd0,    8'd0,   10'd1000, 16'd4096, 16'd48}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // interval between the 3rd and 4th rising tick; flags any two-cycle pulse
  task automatic measure(input bit is_a, output int period, output int wide);
    int seen = 0, cnt = 0, start = 0;
    bit prev = 1'b0, cur;
    period = -1; wide = 0;
    while (seen < 4 && cnt < 40000) begin
      @(negedge clk);
      cnt++;
      cur = is_a ? tick_a : tick_b;
      if (cur && prev) wide = 1;
      if (cur && !prev) begin
        seen++;
        if (seen == 3) start = cnt;
        if (seen == 4) period = cnt - start;
      end
      prev = cur;
    end
  endtask

  task automatic next_gap_b(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tick_b && gap < 40000);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    int per, wide, first_a, first_b, gap;
    string tag;
    // R1: quiet in reset, then first ticks at cycles 2 and 4
    repeat (3) @(negedge clk);
    check("R1 tick_a in reset", tick_a, 0);
    check("R1 tick_b in reset", tick_b, 0);
    rst_n = 1'b1;
    first_a = 0; first_b = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (tick_a && first_a == 0) first_a = i;
      if (tick_b && first_b == 0) first_b = i;
    end
    check("R1 first tick_b cycle", first_b, 2);
    check("R1 first tick_a cycle", first_a, 4);

    // R2..R6, R9, R10: configuration table, no reset between entries
    for (int v = 0; v < NV; v++) begin
      src_int = VECS[v].sel; dbl = VECS[v].d;
      rld_a = VECS[v].ra; th = VECS[v].t; rld_b = VECS[v].rb;
      if (VECS[v].sel) tag = VECS[v].d ? "R3/R10" : "R2/R10";
      else             tag = VECS[v].d ? "R5/R10" : "R4/R10";
      if (VECS[v].ra == 10'd1023 || VECS[v].ra == 10'd0) tag = {tag, "/R9"};
      measure(1'b1, per, wide);
      check($sformatf("%s vec%0d period A", tag, v), per, int'(VECS[v].pa));
      check($sformatf("R7 vec%0d width A", v), wide, 0);
      measure(1'b0, per, wide);
      check($sformatf("R6 vec%0d period B", v), per, int'(VECS[v].pb));
      check($sformatf("R7 vec%0d width B", v), wide, 0);
    end

    // R8: reload changed right after a tick applies from the next overflow
    src_int = 1'b1; dbl = 1'b0; rld_b = 10'd1020;
    measure(1'b0, per, wide);
    check("R8 settle period B", per, 8);
    @(negedge clk);
    while (!tick_b) @(negedge clk);
    rld_b = 10'd1016;
    next_gap_b(gap);
    check("R8 interval with old reload", gap, 8);
    next_gap_b(gap);
    check("R8 interval with new reload", gap, 16);

    // R9: longest port B period
    rld_b = 10'd0;
    measure(1'b0, per, wide);
    check("R9 rld_b=0 period B", per, 2048);

    summary();
  end
endmodule